// File: doc/BRIEF.md
# DMA Search and Termination Unit

This block decides when one DMA channel stops and what happens next. Software first loads a pattern, a mask, an operation count, a base count and a mode word. It then starts the unit with a one-cycle go strobe. While the unit is busy, it takes one data word per valid strobe. It counts the word, compares it against the masked pattern and watches an external end-of-process input. As soon as a stop condition holds, it ends the operation. It then reports every cause that applied and raises the completion actions that the option field selects.

The mode word chooses among three operations. Move operations write data and never compare. Scan operations compare data and never write. Move-and-scan operations do both, so the matching word is still written. The match rule is chosen separately. It can stop on a mismatch, on a full-word match, or on a match of any single byte lane. Base-to-current reload is done internally: the current count takes the base count value when the operation ends, and no memory is accessed. The bus transfers themselves are handled elsewhere.

Top module: `dma_stop_unit`

## Requirements
- R1: After reset, `busy_o`, `cnt_o`, `wr_o`, `term_o`, `cause_o`, `irq_o`, `brld_o` and `crld_o` are all zero.
- R2: The operation encoding is 00 move, 01 scan, 10 move-and-scan, and 11 behaves as move. An accepted beat (`dat_vld_i` while busy) in move or move-and-scan raises `wr_o` for one cycle after that beat. A move operation never produces a match termination.
- R3: A scan operation never raises `wr_o`. Its beats are only compared.
- R4: A mask bit of 1 makes that data bit count as matching whatever the pattern bit is. A mask bit of 0 requires the data bit to equal the pattern bit.
- R5: The stop rule encoding is 00 stop on a mismatch, 01 stop on a full-word match, 10 stop when any byte lane matches, and 11 never stop on data. A stop raises cause bit 2 (match).
- R6: Each accepted beat decrements the count by one. A beat accepted while the count is 1 ends the operation with cause bit 0 (terminal count).
- R7: A count loaded as zero allows 65536 beats, and the last of them ends the operation with terminal count.
- R8: `eop_i` ends a busy operation in the following cycle with cause bit 1, whether or not a beat arrives. A lone end-of-process leaves the count unchanged.
- R9: Causes that occur in the same cycle are all reported together in one single-cycle `term_o` pulse. `busy_o` is low from that cycle on.
- R10: The option bits are 0 for interrupt, 1 for base reload and 2 for chain reload. With `term_o`, `irq_o`, `brld_o` and `crld_o` equal the option bits. They are never high without `term_o`. When the options are zero, no action is raised.
- R11: When base reload is selected, `cnt_o` shows the base count in the cycle of `term_o`.
- R12: While idle, beats and `eop_i` have no effect. While busy, register loads and `go_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pat_we_i | input | 1 | Load pattern (idle only) |
| pat_i | input | DW | Pattern value |
| msk_we_i | input | 1 | Load mask (idle only) |
| msk_i | input | DW | Mask value, 1 = don't care |
| cnt_we_i | input | 1 | Load current count (idle only) |
| cnt_i | input | CW | Current count value, 0 = maximum |
| base_we_i | input | 1 | Load base count (idle only) |
| base_i | input | CW | Base count value |
| mode_we_i | input | 1 | Load operation, stop rule and options (idle only) |
| op_i | input | 2 | Operation type |
| stop_i | input | 2 | Match stop rule |
| opt_i | input | 3 | Completion options |
| go_i | input | 1 | Start operation (idle only) |
| dat_vld_i | input | 1 | Data beat strobe |
| dat_i | input | DW | Data word of the beat |
| eop_i | input | 1 | External end of process, active high |
| busy_o | output | 1 | Operation in progress |
| cnt_o | output | CW | Current count |
| wr_o | output | 1 | Previous beat is to be written |
| term_o | output | 1 | Termination pulse |
| cause_o | output | 3 | Cause bits {match, end-of-process, terminal count} |
| irq_o | output | 1 | Interrupt request |
| brld_o | output | 1 | Base-to-current reload request |
| crld_o | output | 1 | Chain reload request |

## Verification
The bench targets several corner cases, each with a wrong design that would show up.

- A beat together with end-of-process while the count is 1 and the data matches must give one pulse carrying all three causes. A design that prioritises one cause would drop the others, and a design that terminates twice would repeat the pulse.
- A count loaded as zero must last the full 65536 beats. A design that tests for zero instead of one would stop at once.
- A byte-lane match on the upper byte alone must stop the operation. A design that only looks at the low lane would miss it.
- A masked nibble must match. A design with the mask inverted would stop on the wrong word.
- A lone end-of-process must leave the count untouched.
- Beats while idle and loads while busy must change nothing. A design that gates them wrongly would corrupt the count.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    typedef enum logic [1:0] {
        OP_MOVE      = 2'b00,
        OP_SCAN      = 2'b01,
        OP_MOVE_SCAN = 2'b10,
        OP_RSVD      = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        STOP_MISS = 2'b00,
        STOP_WORD = 2'b01,
        STOP_BYTE = 2'b10,
        STOP_NONE = 2'b11
    } stop_e;

    localparam int CAUSE_TC  = 0;
    localparam int CAUSE_EOP = 1;
    localparam int CAUSE_MC  = 2;
    localparam int NCAUSE    = 3;

    localparam int ACT_IRQ   = 0;
    localparam int ACT_BASE  = 1;
    localparam int ACT_CHAIN = 2;
    localparam int NACT      = 3;

endpackage

// File: rtl/dsu_match.sv
module dsu_match
    import dsu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dat_i,
    input  logic [DW-1:0] pat_i,
    input  logic [DW-1:0] msk_i,
    input  stop_e         stop_i,
    output logic          hit_o
);
    localparam int NLANE = DW / 8;

    logic [DW-1:0]    bad;
    logic [NLANE-1:0] lane_ok;
    logic             word_ok;

    assign bad     = (dat_i ^ pat_i) & ~msk_i;
    assign word_ok = (bad == '0);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_ok[g] = (bad[g*8 +: 8] == 8'h00);
    end

    always_comb begin
        unique case (stop_i)
            STOP_MISS: hit_o = ~word_ok;
            STOP_WORD: hit_o = word_ok;
            STOP_BYTE: hit_o = |lane_ok;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsu_count.sv
module dsu_count #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_i,
    input  logic          beat_i,
    output logic [CW-1:0] nxt_o,
    output logic          last_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    assign nxt_o  = beat_i ? (cnt_i - ONE) : cnt_i;
    assign last_o = beat_i && (cnt_i == ONE);
endmodule

// File: rtl/dsu_action.sv
module dsu_action
    import dsu_pkg::*;
(
    input  logic [NCAUSE-1:0] cause_i,
    input  logic [NACT-1:0]   opt_i,
    output logic              any_o,
    output logic [NACT-1:0]   act_o
);
    assign any_o = |cause_i;

    for (genvar g = 0; g < NACT; g++) begin : g_act
        assign act_o[g] = any_o & opt_i[g];
    end
endmodule

// File: rtl/dma_stop_unit.sv
module dma_stop_unit
    import dsu_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pat_we_i,
    input  logic [DW-1:0] pat_i,
    input  logic          msk_we_i,
    input  logic [DW-1:0] msk_i,
    input  logic          cnt_we_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          base_we_i,
    input  logic [CW-1:0] base_i,
    input  logic          mode_we_i,
    input  logic [1:0]    op_i,
    input  logic [1:0]    stop_i,
    input  logic [2:0]    opt_i,
    input  logic          go_i,
    input  logic          dat_vld_i,
    input  logic [DW-1:0] dat_i,
    input  logic          eop_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output logic          wr_o,
    output logic          term_o,
    output logic [2:0]    cause_o,
    output logic          irq_o,
    output logic          brld_o,
    output logic          crld_o
);
    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     base;
        logic [DW-1:0]     pat;
        logic [DW-1:0]     msk;
        op_e               op;
        stop_e             stop;
        logic [NACT-1:0]   opt;
        logic              wr;
        logic              term;
        logic [NCAUSE-1:0] cause;
        logic [NACT-1:0]   act;
    } state_t;

    state_t st_d, st_q;

    logic              beat, eop_hit, hit, last, any;
    logic              does_scan, does_move;
    logic [CW-1:0]     cnt_nxt;
    logic [NCAUSE-1:0] cause;
    logic [NACT-1:0]   act;

    assign beat      = st_q.busy & dat_vld_i;
    assign eop_hit   = st_q.busy & eop_i;
    assign does_scan = (st_q.op == OP_SCAN) || (st_q.op == OP_MOVE_SCAN);
    assign does_move = (st_q.op != OP_SCAN);

    dsu_match #(.DW(DW)) u_match (
        .dat_i  (dat_i),
        .pat_i  (st_q.pat),
        .msk_i  (st_q.msk),
        .stop_i (st_q.stop),
        .hit_o  (hit)
    );

    dsu_count #(.CW(CW)) u_count (
        .cnt_i  (st_q.cnt),
        .beat_i (beat),
        .nxt_o  (cnt_nxt),
        .last_o (last)
    );

    always_comb begin
        cause            = '0;
        cause[CAUSE_TC]  = last;
        cause[CAUSE_EOP] = eop_hit;
        cause[CAUSE_MC]  = beat & does_scan & hit;
    end

    dsu_action u_action (
        .cause_i (cause),
        .opt_i   (st_q.opt),
        .any_o   (any),
        .act_o   (act)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr    = 1'b0;
        st_d.term  = 1'b0;
        st_d.cause = '0;
        st_d.act   = '0;
        if (st_q.busy) begin
            st_d.cnt = cnt_nxt;
            st_d.wr  = beat & does_move;
            if (any) begin
                st_d.busy  = 1'b0;
                st_d.term  = 1'b1;
                st_d.cause = cause;
                st_d.act   = act;
                if (act[ACT_BASE]) begin
                    st_d.cnt = st_q.base;
                end
            end
        end else begin
            if (pat_we_i)  st_d.pat  = pat_i;
            if (msk_we_i)  st_d.msk  = msk_i;
            if (cnt_we_i)  st_d.cnt  = cnt_i;
            if (base_we_i) st_d.base = base_i;
            if (mode_we_i) begin
                st_d.op   = op_e'(op_i);
                st_d.stop = stop_e'(stop_i);
                st_d.opt  = opt_i;
            end
            if (go_i) st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign cnt_o   = st_q.cnt;
    assign wr_o    = st_q.wr;
    assign term_o  = st_q.term;
    assign cause_o = st_q.cause;
    assign irq_o   = st_q.act[ACT_IRQ];
    assign brld_o  = st_q.act[ACT_BASE];
    assign crld_o  = st_q.act[ACT_CHAIN];
endmodule

// File: rtl/dma_stop_unit_chk.sv
module dma_stop_unit_chk #(
    parameter int CW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cnt_we_i,
    input logic          dat_vld_i,
    input logic          eop_i,
    input logic          busy_o,
    input logic [CW-1:0] cnt_o,
    input logic          term_o,
    input logic [2:0]    cause_o,
    input logic          irq_o,
    input logic          brld_o,
    input logic          crld_o
);
    p_cause_with_term_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |-> (cause_o != 3'b000))
        else $error("p_cause_with_term_r9");

    p_no_cause_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !term_o |-> (cause_o == 3'b000))
        else $error("p_no_cause_idle_r9");

    p_term_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |=> !term_o)
        else $error("p_term_single_r9");

    p_act_needs_term_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o || brld_o || crld_o) |-> term_o)
        else $error("p_act_needs_term_r10");

    p_term_clears_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |-> !busy_o)
        else $error("p_term_clears_busy_r9");

    p_eop_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && eop_i) |=> (term_o && cause_o[1]))
        else $error("p_eop_stops_r8");

    p_tc_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && dat_vld_i && cnt_o == CW'(1)) |=> (term_o && cause_o[0]))
        else $error("p_tc_stops_r6");

    p_idle_cnt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !cnt_we_i) |=> $stable(cnt_o))
        else $error("p_idle_cnt_r12");
endmodule

bind dma_stop_unit dma_stop_unit_chk #(.CW(CW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_we_i  (cnt_we_i),
    .dat_vld_i (dat_vld_i),
    .eop_i     (eop_i),
    .busy_o    (busy_o),
    .cnt_o     (cnt_o),
    .term_o    (term_o),
    .cause_o   (cause_o),
    .irq_o     (irq_o),
    .brld_o    (brld_o),
    .crld_o    (crld_o)
);

// File: tb/dma_stop_unit_tb_top.sv
module dma_stop_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pat_we = 0, msk_we = 0, cnt_we = 0, base_we = 0, mode_we = 0, go = 0;
    logic [15:0] pat = 0, msk = 0, cnt = 0, base = 0, dat = 0;
    logic [1:0]  op = 0, stop = 0;
    logic [2:0]  opt = 0;
    logic        vld = 0, eop = 0;
    logic        busy_o, wr_o, term_o, irq_o, brld_o, crld_o;
    logic [15:0] cnt_o;
    logic [2:0]  cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dma_stop_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .pat_we_i(pat_we), .pat_i(pat), .msk_we_i(msk_we), .msk_i(msk),
        .cnt_we_i(cnt_we), .cnt_i(cnt), .base_we_i(base_we), .base_i(base),
        .mode_we_i(mode_we), .op_i(op), .stop_i(stop), .opt_i(opt),
        .go_i(go), .dat_vld_i(vld), .dat_i(dat), .eop_i(eop),
        .busy_o(busy_o), .cnt_o(cnt_o), .wr_o(wr_o), .term_o(term_o),
        .cause_o(cause_o), .irq_o(irq_o), .brld_o(brld_o), .crld_o(crld_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_busy = 0, m_cnt = 0, m_base = 0, m_pat = 0, m_msk = 0;
    int m_op = 0, m_stop = 0, m_opt = 0;
    int m_wr = 0, m_term = 0, m_cause = 0, m_act = 0;

    function automatic int ref_hit(int d);
        int lo_ok = 1, hi_ok = 1;
        if (m_stop == 3) return 0;
        for (int i = 0; i < 16; i++) begin
            if (((m_msk >> i) & 1) == 0 && ((d >> i) & 1) != ((m_pat >> i) & 1)) begin
                if (i < 8) lo_ok = 0; else hi_ok = 0;
            end
        end
        if (m_stop == 0) return (lo_ok && hi_ok) ? 0 : 1;
        if (m_stop == 1) return (lo_ok && hi_ok) ? 1 : 0;
        return (lo_ok || hi_ok) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_base = 0; m_pat = 0; m_msk = 0;
            m_op = 0; m_stop = 0; m_opt = 0;
            m_wr = 0; m_term = 0; m_cause = 0; m_act = 0;
        end else begin
            int b, e, tc, mc;
            m_wr = 0; m_term = 0; m_cause = 0; m_act = 0;
            if (m_busy != 0) begin
                b  = vld ? 1 : 0;
                e  = eop ? 1 : 0;
                tc = (b != 0 && m_cnt == 1) ? 1 : 0;
                mc = (b != 0 && (m_op == 1 || m_op == 2)) ? ref_hit(int'(dat)) : 0;
                if (b != 0) m_cnt = (m_cnt + 65535) % 65536;
                m_wr = (b != 0 && m_op != 1) ? 1 : 0;
                m_cause = mc * 4 + e * 2 + tc;
                if (m_cause != 0) begin
                    m_busy = 0;
                    m_term = 1;
                    m_act  = m_opt;
                    if ((m_opt & 2) != 0) m_cnt = m_base;
                end
            end else begin
                if (pat_we)  m_pat  = int'(pat);
                if (msk_we)  m_msk  = int'(msk);
                if (cnt_we)  m_cnt  = int'(cnt);
                if (base_we) m_base = int'(base);
                if (mode_we) begin
                    m_op = int'(op); m_stop = int'(stop); m_opt = int'(opt);
                end
                if (go) m_busy = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 busy", int'(busy_o), m_busy);
            check("R6 count", int'(cnt_o), m_cnt);
            check("R2 write", int'(wr_o), m_wr);
            check("R8 term", int'(term_o), m_term);
            check("R9 cause", int'(cause_o), m_cause);
            check("R10 actions", int'({crld_o, brld_o, irq_o}), m_act);
        end
    end

    task automatic setup(input logic [1:0] o, input logic [1:0] s, input logic [2:0] op_bits,
                         input logic [15:0] p, input logic [15:0] m,
                         input logic [15:0] c, input logic [15:0] bc);
        pat_we = 1; msk_we = 1; cnt_we = 1; base_we = 1; mode_we = 1;
        op = o; stop = s; opt = op_bits; pat = p; msk = m; cnt = c; base = bc;
        @(negedge clk);
        pat_we = 0; msk_we = 0; cnt_we = 0; base_we = 0; mode_we = 0;
        go = 1;
        @(negedge clk);
        go = 0;
    endtask

    task automatic beat(input logic [15:0] d);
        vld = 1; dat = d;
        @(negedge clk);
        vld = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 term", int'({term_o, cause_o, irq_o, brld_o, crld_o, wr_o}), 0);
        rst_n = 1;
        @(negedge clk);

        // R2 move never matches, R6 terminal count, R10 irq option
        setup(2'b00, 2'b01, 3'b001, 16'hAAAA, 16'h0000, 16'd3, 16'd0);
        beat(16'hAAAA);
        check("R2 write", int'(wr_o), 1);
        check("R2 no match", int'(term_o), 0);
        beat(16'h0001);
        @(negedge clk);
        beat(16'h0002);
        check("R6 tc", int'(cause_o), 1);
        check("R10 irq", int'({crld_o, brld_o, irq_o}), 1);
        @(negedge clk);

        // R3 scan no write, R4 mask
        setup(2'b01, 2'b01, 3'b000, 16'h1234, 16'h00F0, 16'd10, 16'd0);
        beat(16'h1200);
        check("R3 no write", int'(wr_o), 0);
        check("R4 unmasked bit differs", int'(term_o), 0);
        beat(16'h12C4);
        check("R4 masked match", int'(cause_o), 4);
        check("R10 no actions", int'({crld_o, brld_o, irq_o}), 0);
        @(negedge clk);

        // R5 stop on mismatch, move-and-scan writes
        setup(2'b10, 2'b00, 3'b100, 16'h5555, 16'h0000, 16'd10, 16'd0);
        beat(16'h5555);
        check("R5 miss rule match continues", int'(term_o), 0);
        beat(16'h5554);
        check("R5 miss rule stops", int'(cause_o), 4);
        check("R2 move-scan writes", int'(wr_o), 1);
        @(negedge clk);

        // R5 byte rule, upper lane only
        setup(2'b01, 2'b10, 3'b000, 16'hABCD, 16'h0000, 16'd10, 16'd0);
        beat(16'h1234);
        check("R5 byte none", int'(term_o), 0);
        beat(16'hAB00);
        check("R5 byte upper lane", int'(cause_o), 4);
        @(negedge clk);

        // R5 never rule
        setup(2'b01, 2'b11, 3'b000, 16'h0000, 16'h0000, 16'd2, 16'd0);
        beat(16'h0000);
        beat(16'h0000);
        check("R5 never rule only tc", int'(cause_o), 1);
        @(negedge clk);

        // R8 lone end-of-process
        setup(2'b00, 2'b11, 3'b100, 16'h0, 16'h0, 16'd5, 16'd0);
        @(negedge clk);
        eop = 1; @(negedge clk); eop = 0;
        check("R8 eop cause", int'(cause_o), 2);
        check("R8 count kept", int'(cnt_o), 5);
        @(negedge clk);

        // R9 coincident causes, R11 base reload
        setup(2'b01, 2'b01, 3'b111, 16'h0007, 16'h0000, 16'd1, 16'd40);
        eop = 1; beat(16'h0007); eop = 0;
        check("R9 all causes", int'(cause_o), 7);
        check("R10 all actions", int'({crld_o, brld_o, irq_o}), 7);
        check("R11 base count", int'(cnt_o), 40);
        @(negedge clk);
        check("R9 single pulse", int'(term_o), 0);

        setup(2'b00, 2'b11, 3'b010, 16'h0, 16'h0, 16'd2, 16'd9);
        beat(16'h1111);
        beat(16'h2222);
        check("R11 reload", int'(cnt_o), 9);
        @(negedge clk);

        // R12 idle beats and busy loads ignored
        vld = 1; eop = 1; dat = 16'h0;
        repeat (3) @(negedge clk);
        vld = 0; eop = 0;
        check("R12 idle term", int'(term_o), 0);
        check("R12 idle cnt", int'(cnt_o), 9);
        setup(2'b00, 2'b11, 3'b000, 16'h0, 16'h0, 16'd4, 16'd0);
        cnt_we = 1; cnt = 16'd100; go = 1;
        @(negedge clk);
        cnt_we = 0; go = 0;
        check("R12 busy load", int'(cnt_o), 4);
        eop = 1; @(negedge clk); eop = 0;
        @(negedge clk);

        // R7 zero count means 65536 beats
        setup(2'b00, 2'b11, 3'b000, 16'h0, 16'h0, 16'd0, 16'd0);
        vld = 1; dat = 16'h0F0F;
        repeat (65535) @(negedge clk);
        check("R7 still busy", int'(busy_o), 1);
        @(negedge clk);
        vld = 0;
        check("R7 tc", int'(cause_o), 1);
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule